// File: doc/BRIEF.md
# Up/Down Timer with Compare Outputs

A 16-bit timer that counts from zero up to a terminal value, then back down to zero, again and again. The terminal value is the compare value of channel 0. Two further compare channels each drive one output pin. Each pin follows a 3-bit output mode that chooses what it does on compare events:

- set, clear or toggle;
- act according to the count direction;
- take one edge from the channel's own match and the opposite edge from the terminal match.

Four event flags record compare and overflow events whatever their masks say. A combined flag and an interrupt request are derived from those flags through per-event masks and a module-level enable. Control and configuration come in on plain ports.

Top module: `updown_cmp_timer`

## Requirements
- R1: While `rst_n` is low and until the first enabled edge after its release, `count` is 0, `count_down` is 0 (up), and `cmp_out`, `ch_flag`, `ovf_flag`, `cpu_flag` and `irq` are all 0.
- R2: On each clock edge with `cnt_en` high, the count moves as follows:
  - Counting up below the terminal value (`cmp_vals[15:0]`), the count increments.
  - Counting up at or above the terminal value, the count switches to down and the next count is count−1 (it stays 0 if the count is already 0).
  - Counting down above 0, the count decrements.
  - Counting down at 0, the count switches to up and the next count is 1 (0 when the terminal value is 0).
  - With `cnt_en` low, the count and the direction hold.
- R3: An overflow event occurs in the cycle after an enabled edge that leaves the counter either counting up at the terminal value or counting down at 0. `ovf_flag` is set on the following edge.
- R4: A compare event for channel k occurs in the cycle after an enabled edge that leaves `count` equal to `cmp_vals[16k+15:16k]`. That makes exactly one event per arrival. A counter held by `cnt_en` low produces no further events.
- R5: Output modes (`mode_sel[3(k-1)+2:3(k-1)]` for pin k, pin k on `cmp_out[k-1]`), part 1. On a channel k event, mode 0 sets the pin, mode 1 clears it and mode 2 toggles it. The pin updates on the edge that ends the event cycle.
- R6: Output modes, part 2. Mode 3 sets the pin on an event while counting up and clears it on an event while counting down. Mode 4 does the opposite. An arrival at the terminal value counts as up; an arrival at 0 counts as down.
- R7: Output modes, part 3. Mode 5 sets the pin on the channel's own event and clears it on a channel 0 event. Mode 6 clears on the own event and sets on a channel 0 event. When both events occur in one cycle, the own event decides.
- R8: In mode 7 the pin holds its value.
- R9: Flag bits:
  - Each bit of `ch_flag` (bit k = channel k) and `ovf_flag` is set by its event regardless of its mask.
  - A flag is cleared by a one-cycle high on its bit of `ch_clr` or on `ovf_clr`.
  - An event in the same cycle as a clear wins.
- R10: `cpu_flag` is high exactly when some flag is set and its mask (`ch_mask` bit k, or `ovf_mask`) is 1, in the same cycle.
- R11: `irq` equals `cpu_flag` AND `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| cmp_vals | input | 48 | Compare values; channel k at bits 16k+15:16k, channel 0 is terminal |
| mode_sel | input | 6 | Output modes, 3 bits per pin channel 1..2 |
| ch_mask | input | 3 | Per-channel event masks |
| ovf_mask | input | 1 | Overflow mask |
| irq_en | input | 1 | Module interrupt enable |
| ch_clr | input | 3 | Per-channel flag clear strobes |
| ovf_clr | input | 1 | Overflow flag clear strobe |
| count | output | 16 | Counter value |
| count_down | output | 1 | Direction, 1 = counting down |
| cmp_out | output | 2 | Compare output pins for channels 1 and 2 |
| ch_flag | output | 3 | Per-channel event flags |
| ovf_flag | output | 1 | Overflow flag |
| cpu_flag | output | 1 | Combined masked flag |
| irq | output | 1 | Interrupt request |

## Verification
The count and the direction change on the enabled edge itself. Compare and overflow events form in the cycle that follows. Pins and flags therefore change one edge after that, two edges after the edge that moved the counter, while `cpu_flag` and `irq` follow the flags and the masks within the same cycle. The bench drives inputs 2 ns after a rising edge and holds a behavioural model that steps on the same rising edge. It compares every output at the falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    OM_SET          = 3'd0,
    OM_CLR          = 3'd1,
    OM_TOG          = 3'd2,
    OM_UP_SET       = 3'd3,
    OM_UP_CLR       = 3'd4,
    OM_OWN_SET      = 3'd5,
    OM_OWN_CLR      = 3'd6,
    OM_HOLD         = 3'd7
  } out_mode_e;

  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } dir_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] term,
  output logic [W-1:0] count,
  output dir_e         dir,
  output logic         fresh
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_d;
  dir_e         dir_d;

  always_comb begin
    cnt_d = count;
    dir_d = dir;
    if (en) begin
      if (dir == DIR_UP) begin
        if (count >= term) begin
          dir_d = DIR_DOWN;
          cnt_d = (count == '0) ? '0 : count - ONE;
        end else begin
          cnt_d = count + ONE;
        end
      end else begin
        if (count == '0) begin
          dir_d = DIR_UP;
          cnt_d = (term == '0) ? '0 : ONE;
        end else begin
          cnt_d = count - ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      dir   <= DIR_UP;
      fresh <= 1'b0;
    end else begin
      count <= cnt_d;
      dir   <= dir_d;
      fresh <= en;
    end
  end
endmodule

// File: rtl/tmr_match.sv
module tmr_match
  import tmr_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic           fresh,
  input  logic [W-1:0]   count,
  input  dir_e           dir,
  input  logic [NCH*W-1:0] cmp_vals,
  output logic [NCH-1:0] ch_evt,
  output logic           ovf_evt
);
  logic [W-1:0] term;
  assign term = cmp_vals[W-1:0];

  for (genvar k = 0; k < NCH; k++) begin : g_cmp
    assign ch_evt[k] = fresh && (count == cmp_vals[k*W +: W]);
  end

  always_comb begin
    ovf_evt = 1'b0;
    if (fresh) begin
      if (dir == DIR_UP) ovf_evt = (count == term);
      else               ovf_evt = (count == '0);
    end
  end
endmodule

// File: rtl/tmr_outmode.sv
module tmr_outmode
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       own_evt,
  input  logic       term_evt,
  input  logic       down,
  output logic       pin
);
  logic      pin_d;
  out_mode_e mode_e;

  assign mode_e = out_mode_e'(mode);

  always_comb begin
    pin_d = pin;
    unique case (mode_e)
      OM_SET:     if (own_evt) pin_d = 1'b1;
      OM_CLR:     if (own_evt) pin_d = 1'b0;
      OM_TOG:     if (own_evt) pin_d = ~pin;
      OM_UP_SET:  if (own_evt) pin_d = ~down;
      OM_UP_CLR:  if (own_evt) pin_d = down;
      OM_OWN_SET: begin
        if (own_evt)       pin_d = 1'b1;
        else if (term_evt) pin_d = 1'b0;
      end
      OM_OWN_CLR: begin
        if (own_evt)       pin_d = 1'b0;
        else if (term_evt) pin_d = 1'b1;
      end
      OM_HOLD:    pin_d = pin;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= pin_d;
  end
endmodule

// File: rtl/tmr_flags.sv
module tmr_flags #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  input  logic         irq_en,
  output logic [N-1:0] flags,
  output logic         cpu_flag,
  output logic         irq
);
  logic [N-1:0] flags_d;

  always_comb begin
    flags_d = (flags & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flags_d;
  end

  assign cpu_flag = |(flags & mask);
  assign irq      = cpu_flag & irq_en;
endmodule

// File: rtl/updown_cmp_timer.sv
module updown_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cnt_en,
  input  logic [NCH*W-1:0]   cmp_vals,
  input  logic [(NCH-1)*3-1:0] mode_sel,
  input  logic [NCH-1:0]     ch_mask,
  input  logic               ovf_mask,
  input  logic               irq_en,
  input  logic [NCH-1:0]     ch_clr,
  input  logic               ovf_clr,
  output logic [W-1:0]       count,
  output logic               count_down,
  output logic [NCH-2:0]     cmp_out,
  output logic [NCH-1:0]     ch_flag,
  output logic               ovf_flag,
  output logic               cpu_flag,
  output logic               irq
);
  localparam int NFLG = NCH + 1;

  dir_e           dir;
  logic           fresh;
  logic [NCH-1:0] ch_evt;
  logic           ovf_evt;
  logic [NFLG-1:0] flags;

  tmr_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cnt_en),
    .term  (cmp_vals[W-1:0]),
    .count (count),
    .dir   (dir),
    .fresh (fresh)
  );

  tmr_match #(.W(W), .NCH(NCH)) u_match (
    .fresh    (fresh),
    .count    (count),
    .dir      (dir),
    .cmp_vals (cmp_vals),
    .ch_evt   (ch_evt),
    .ovf_evt  (ovf_evt)
  );

  for (genvar k = 1; k < NCH; k++) begin : g_pin
    tmr_outmode u_om (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_sel[3*(k-1) +: 3]),
      .own_evt  (ch_evt[k]),
      .term_evt (ch_evt[0]),
      .down     (dir == DIR_DOWN),
      .pin      (cmp_out[k-1])
    );
  end

  tmr_flags #(.N(NFLG)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      ({ovf_evt, ch_evt}),
    .clr      ({ovf_clr, ch_clr}),
    .mask     ({ovf_mask, ch_mask}),
    .irq_en   (irq_en),
    .flags    (flags),
    .cpu_flag (cpu_flag),
    .irq      (irq)
  );

  assign ch_flag    = flags[NCH-1:0];
  assign ovf_flag   = flags[NCH];
  assign count_down = (dir == DIR_DOWN);
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W   = 16,
  parameter int NCH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cnt_en,
  input logic [W-1:0]         count,
  input logic                 count_down,
  input logic [(NCH-1)*3-1:0] mode_sel,
  input logic [NCH-2:0]       cmp_out,
  input logic [NCH-1:0]       ch_evt,
  input logic                 ovf_evt,
  input logic [NCH-1:0]       ch_flag,
  input logic                 ovf_flag,
  input logic                 irq,
  input logic                 irq_en
);
  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_en |=> (count == $past(count) + 1'b1) || (count == $past(count) - 1'b1) ||
               (count == '0 && $past(count) == '0));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(count) && $stable(count_down));

  // R3
  ovf_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag);

  // R9
  ovf_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(ovf_evt));

  // R11
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);

  for (genvar k = 0; k < NCH; k++) begin : g_flag
    // R9
    ch_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_flag[k]) |-> $past(ch_evt[k]));
  end

  for (genvar k = 1; k < NCH; k++) begin : g_hold
    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[3*(k-1) +: 3] == 3'd7) |=> $stable(cmp_out[k-1]));
  end
endmodule

bind updown_cmp_timer tmr_checker #(.W(W), .NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_en     (cnt_en),
  .count      (count),
  .count_down (count_down),
  .mode_sel   (mode_sel),
  .cmp_out    (cmp_out),
  .ch_evt     (ch_evt),
  .ovf_evt    (ovf_evt),
  .ch_flag    (ch_flag),
  .ovf_flag   (ovf_flag),
  .irq        (irq),
  .irq_en     (irq_en)
);

// File: tb/updown_cmp_timer_bench.sv
module updown_cmp_timer_bench;
  logic        clk;
  logic        rst_n;
  logic        cnt_en;
  logic [47:0] cmp_vals;
  logic [5:0]  mode_sel;
  logic [2:0]  ch_mask;
  logic        ovf_mask;
  logic        irq_en;
  logic [2:0]  ch_clr;
  logic        ovf_clr;
  logic [15:0] count;
  logic        count_down;
  logic [1:0]  cmp_out;
  logic [2:0]  ch_flag;
  logic        ovf_flag;
  logic        cpu_flag;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  updown_cmp_timer u_updown_cmp_timer (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cmp_vals(cmp_vals),
    .mode_sel(mode_sel), .ch_mask(ch_mask), .ovf_mask(ovf_mask),
    .irq_en(irq_en), .ch_clr(ch_clr), .ovf_clr(ovf_clr), .count(count),
    .count_down(count_down), .cmp_out(cmp_out), .ch_flag(ch_flag),
    .ovf_flag(ovf_flag), .cpu_flag(cpu_flag), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural reference state
  int       m_cnt;
  bit       m_down;
  bit       m_fresh;
  bit [2:0] m_chf;
  bit       m_ovf;
  bit [1:0] m_pin;

  function automatic int fld(input int k);
    return int'(cmp_vals[16*k +: 16]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_down = 0; m_fresh = 0; m_chf = '0; m_ovf = 0; m_pin = '0;
    end else begin
      bit [2:0] ev;
      bit       ovf_ev;
      int       term;
      term = fld(0);
      for (int k = 0; k < 3; k++) ev[k] = m_fresh && (m_cnt == fld(k));
      ovf_ev = m_fresh && (m_down ? (m_cnt == 0) : (m_cnt == term));
      for (int p = 0; p < 2; p++) begin
        int md;
        md = int'(mode_sel[3*p +: 3]);
        if (md == 0 && ev[p+1]) m_pin[p] = 1;
        if (md == 1 && ev[p+1]) m_pin[p] = 0;
        if (md == 2 && ev[p+1]) m_pin[p] = !m_pin[p];
        if (md == 3 && ev[p+1]) m_pin[p] = !m_down;
        if (md == 4 && ev[p+1]) m_pin[p] = m_down;
        if (md == 5) begin
          if (ev[p+1]) m_pin[p] = 1; else if (ev[0]) m_pin[p] = 0;
        end
        if (md == 6) begin
          if (ev[p+1]) m_pin[p] = 0; else if (ev[0]) m_pin[p] = 1;
        end
      end
      m_chf = (m_chf & ~ch_clr) | ev;
      m_ovf = (m_ovf && !ovf_clr) || ovf_ev;
      if (cnt_en) begin
        if (!m_down) begin
          if (m_cnt >= term) begin m_down = 1; m_cnt = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_down = 0; m_cnt = (term == 0) ? 0 : 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_fresh = cnt_en;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic string pin_req(input int md);
    if (md <= 2) return "R5";
    if (md <= 4) return "R6";
    if (md <= 6) return "R7";
    return "R8";
  endfunction

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_cpu;
      exp_cpu = |({m_ovf, m_chf} & {ovf_mask, ch_mask});
      chk(int'(count) == m_cnt, "R2", "count", int'(count), m_cnt);
      chk(count_down == m_down, "R2", "direction", int'(count_down), int'(m_down));
      for (int p = 0; p < 2; p++)
        chk(cmp_out[p] == m_pin[p], pin_req(int'(mode_sel[3*p +: 3])), "pin",
            int'(cmp_out[p]), int'(m_pin[p]));
      // R4 and R9: channel flags follow one event per arrival
      chk(ch_flag == m_chf, "R9", "channel flags", int'(ch_flag), int'(m_chf));
      chk(ovf_flag == m_ovf, "R3", "overflow flag", int'(ovf_flag), int'(m_ovf));
      chk(cpu_flag == exp_cpu, "R10", "cpu flag", int'(cpu_flag), int'(exp_cpu));
      chk(irq == (exp_cpu && irq_en), "R11", "irq", int'(irq), int'(exp_cpu && irq_en));
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  initial begin
    int cfg_t[3];
    int cfg_a[3];
    int cfg_b[3];
    cfg_t[0] = 20; cfg_a[0] = 7;  cfg_b[0] = 0;
    cfg_t[1] = 20; cfg_a[1] = 20; cfg_b[1] = 13;
    cfg_t[2] = 9;  cfg_a[2] = 0;  cfg_b[2] = 9;

    rst_n = 0; cnt_en = 0; cmp_vals = '0; mode_sel = '0; ch_mask = '0;
    ovf_mask = 0; irq_en = 0; ch_clr = '0; ovf_clr = 0;
    cmp_vals = {16'd5, 16'd3, 16'd10};
    repeat (3) @(posedge clk);
    #3;
    // R1: reset state
    chk(count == 16'd0 && count_down == 1'b0, "R1", "counter in reset", int'(count), 0);
    chk(cmp_out == 2'b00 && ch_flag == 3'b000 && ovf_flag == 1'b0, "R1", "pins/flags in reset",
        int'({cmp_out, ch_flag, ovf_flag}), 0);
    chk(cpu_flag == 1'b0 && irq == 1'b0, "R1", "request in reset", int'({cpu_flag, irq}), 0);
    ch_mask = 3'b111; ovf_mask = 1; irq_en = 1;
    @(negedge clk);
    rst_n = 1;
    step();
    #3;
    chk(count == 16'd0 && cmp_out == 2'b00 && irq == 1'b0, "R1", "after release",
        int'({count, cmp_out, irq}), 0);

    for (int c = 0; c < 3; c++) begin
      for (int m = 0; m < 8; m++) begin
        step();
        cmp_vals = {16'(cfg_b[c]), 16'(cfg_a[c]), 16'(cfg_t[c])};
        mode_sel = {3'((m + 3) % 8), 3'(m)};
        ch_mask  = 3'(m + c);
        ovf_mask = m[1];
        irq_en   = m[0] ^ c[0];
        for (int i = 0; i < 100; i++) begin
          cnt_en  = ((i % 23) != 22);
          ch_clr  = ((i % 17) == 0) ? 3'(i) : 3'b000;
          ovf_clr = ((i % 19) == 0);
          step();
        end
        ch_clr = '0; ovf_clr = 0;
      end
    end

    // R4: a held counter creates no new event
    cmp_vals = {16'd12, 16'd5, 16'd20};
    mode_sel = 6'b000_010;
    cnt_en = 1;
    while (count != 16'd5) step();
    cnt_en = 0;
    step();
    ch_clr = 3'b111; ovf_clr = 1;
    step();
    ch_clr = '0; ovf_clr = 0;
    repeat (10) step();
    chk(ch_flag[1] == 1'b0, "R4", "flag while held", int'(ch_flag[1]), 0);
    chk(count == 16'd5, "R2", "held count", int'(count), 5);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule